// File: doc/BRIEF.md
# Dual-Mode Synchronous FIFO with Retransmit

This block is a single-clock FIFO whose read side works in one of two timing modes. In standard mode the output holds its value until a read is requested explicitly. In fall-through mode the oldest stored word moves to the output on its own. Later words still need a read request before they replace it. The mode is sampled while master reset is held and stays fixed until the next master reset.

A partial reset empties the FIFO but keeps the mode that was chosen. A retransmit request moves the read pointer back to the first memory location, so the words written since the last reset can be read a second time.

There are two status outputs whose meaning depends on the mode. In standard mode they report empty and full. In fall-through mode they report that no word is waiting at the output, and that the memory cannot take another word. A half-full flag reports the memory occupancy in the same way in both modes. All enables and resets are active low and are sampled on the rising clock edge.

Top module: `dual_mode_fifo`

## Requirements
- R1: At every rising edge where `mrst_n` is low, `mode_sel_i` is captured: 0 selects standard mode and 1 selects fall-through mode. The captured mode stays unchanged through partial resets, retransmits and all traffic until the next master reset.
- R2: In standard mode, `rd_data_o` changes only after a rising edge where `rd_en_n` is low and the FIFO is not empty. It then shows the oldest unread word. A write into an empty FIFO leaves the output unchanged.
- R3: In fall-through mode, a word written into an empty FIFO at edge k appears on `rd_data_o` after edge k+1, with no read request. While a word is shown, the next word replaces it only after an edge where `rd_en_n` is low.
- R4: `rd_flag_o` = 1 means the memory is empty in standard mode, and means no valid word is at the output in fall-through mode. `wr_flag_o` = 1 means the memory holds DEPTH words, in both modes.
- R5: `half_o` is 1 exactly when the memory holds more than DEPTH/2 words. In fall-through mode, the word shown at the output is not counted.
- R6: After master reset, the FIFO is empty, both pointers are at location 0, `rd_flag_o` is 1, `wr_flag_o` and `half_o` are 0, and the output register is 0.
- R7: A rising edge where `prst_n` is low clears both pointers and the output register and recomputes the flags. The captured mode is kept.
- R8: A rising edge where `retx_n` is low moves the read pointer to location 0. Reads then replay from the first word written since the last reset, provided no more than DEPTH words have been written since that reset. In fall-through mode, the output is marked invalid on that edge and the first word appears after the next edge. Retransmit takes priority over a read in the same cycle.
- R9: A write while the memory is full is discarded and no pointer moves. A read while the FIFO is empty does nothing, and the output keeps its last value.
- R10: While `oe_n` is 1, `rd_data_o` shows the idle value 0. Stored data and the output register are not affected, and the held word returns when `oe_n` goes back to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by the write and read sides |
| mrst_n | input | 1 | Master reset, active low, synchronous |
| prst_n | input | 1 | Partial reset, active low, synchronous, keeps the mode |
| mode_sel_i | input | 1 | Mode select, sampled during master reset (1 = fall-through) |
| wr_en_n | input | 1 | Write enable, active low |
| wr_data_i | input | W | Write data |
| rd_en_n | input | 1 | Read enable, active low |
| oe_n | input | 1 | Output enable, active low |
| retx_n | input | 1 | Retransmit request, active low |
| rd_data_o | output | W | Read data, 0 while output is disabled |
| rd_flag_o | output | 1 | Empty (standard) or output-not-ready (fall-through) |
| wr_flag_o | output | 1 | Full (standard) or input-not-ready (fall-through) |
| half_o | output | 1 | Memory holds more than DEPTH/2 words |

## Verification
The bench goes after the edges of the word count and of the timing modes.

- A design with an off-by-one half-full compare would raise `half_o` at exactly DEPTH/2 words.
- A design that wrote into a full memory would corrupt the oldest word or show an extra word when the FIFO is drained.
- A design that read from an empty memory would change the held output word.

The bench writes into an empty FIFO in each mode. A standard-mode design that leaked data through, or a fall-through design that needed a read or showed the word one cycle early, is caught at the output. It also checks that retransmit replays from the first word in both modes, and that partial reset keeps fall-through mode. A design that re-sampled the mode pin on partial reset would fall back to standard timing there.

// File: rtl/dmf_pkg.sv
package dmf_pkg;

    // Read-side output stage states
    typedef enum logic [1:0] {
        ST_STD     = 2'd0,  // standard mode: output moves only on request
        ST_FT_DRY  = 2'd1,  // fall-through: no valid word at the output
        ST_FT_HOLD = 2'd2   // fall-through: head word is shown
    } out_st_e;

endpackage

// File: rtl/dmf_store.sv
module dmf_store #(
    parameter int W     = 8,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);

    logic [W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
    end

    assign rdata = cells[raddr];

endmodule

// File: rtl/dmf_ptrs.sv
module dmf_ptrs #(
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          mrst_n,
    input  logic          prst_n,
    input  logic          push,
    input  logic          pop,
    input  logic          rewind,
    output logic [AW-1:0] waddr,
    output logic [AW-1:0] raddr,
    output logic [AW:0]   count,
    output logic          empty,
    output logic          full,
    output logic          half
);

    localparam logic [AW:0] FULL_CNT = (AW+1)'(DEPTH);
    localparam logic [AW:0] HALF_CNT = (AW+1)'(DEPTH / 2);

    logic [AW:0] wptr_q;
    logic [AW:0] rptr_q;

    always_ff @(posedge clk) begin
        if (!mrst_n || !prst_n) begin
            wptr_q <= '0;
            rptr_q <= '0;
        end else begin
            if (push) begin
                wptr_q <= wptr_q + 1'b1;
            end
            if (rewind) begin
                rptr_q <= '0;
            end else if (pop) begin
                rptr_q <= rptr_q + 1'b1;
            end
        end
    end

    assign waddr = wptr_q[AW-1:0];
    assign raddr = rptr_q[AW-1:0];
    assign count = wptr_q - rptr_q;
    assign empty = (count == '0);
    assign full  = (count == FULL_CNT);
    assign half  = (count > HALF_CNT);

endmodule

// File: rtl/dual_mode_fifo.sv
module dual_mode_fifo
    import dmf_pkg::*;
#(
    parameter int W     = 8,
    parameter int DEPTH = 16
) (
    input  logic         clk,
    input  logic         mrst_n,
    input  logic         prst_n,
    input  logic         mode_sel_i,
    input  logic         wr_en_n,
    input  logic [W-1:0] wr_data_i,
    input  logic         rd_en_n,
    input  logic         oe_n,
    input  logic         retx_n,
    output logic [W-1:0] rd_data_o,
    output logic         rd_flag_o,
    output logic         wr_flag_o,
    output logic         half_o
);

    localparam int AW = $clog2(DEPTH);

    logic          mode_q;     // 1 = fall-through
    out_st_e       state_q;
    out_st_e       state_nx;
    logic          push;
    logic          pop;
    logic [AW-1:0] waddr;
    logic [AW-1:0] raddr;
    logic [AW:0]   mem_cnt;
    logic          mem_empty;
    logic          mem_full;
    logic          mem_half;
    logic [W-1:0]  mem_rd;
    logic [W-1:0]  dout_q;

    function automatic out_st_e home_state(input logic ft);
        return ft ? ST_FT_DRY : ST_STD;
    endfunction

    // Mode capture: only while master reset is held
    always_ff @(posedge clk) begin
        if (!mrst_n) begin
            mode_q <= mode_sel_i;
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!mrst_n) begin
            state_q <= home_state(mode_sel_i);
        end else if (!prst_n) begin
            state_q <= home_state(mode_q);
        end else begin
            state_q <= state_nx;
        end
    end

    assign push = !wr_en_n && !mem_full;

    // Next state and read strobe
    always_comb begin
        state_nx = state_q;
        pop      = 1'b0;
        unique case (state_q)
            ST_STD: begin
                pop = !rd_en_n && !mem_empty && retx_n;
            end
            ST_FT_DRY: begin
                if (retx_n && !mem_empty) begin
                    pop      = 1'b1;
                    state_nx = ST_FT_HOLD;   // fetch
                end
            end
            ST_FT_HOLD: begin
                if (!retx_n) begin
                    state_nx = ST_FT_DRY;    // rewind
                end else if (!rd_en_n) begin
                    if (!mem_empty) begin
                        pop = 1'b1;          // advance
                    end else begin
                        state_nx = ST_FT_DRY; // drain
                    end
                end
            end
            default: state_nx = home_state(mode_q);
        endcase
    end

    dmf_ptrs #(.DEPTH(DEPTH)) u_ptrs (
        .clk    (clk),
        .mrst_n (mrst_n),
        .prst_n (prst_n),
        .push   (push),
        .pop    (pop),
        .rewind (!retx_n),
        .waddr  (waddr),
        .raddr  (raddr),
        .count  (mem_cnt),
        .empty  (mem_empty),
        .full   (mem_full),
        .half   (mem_half)
    );

    dmf_store #(.W(W), .DEPTH(DEPTH)) u_mem (
        .clk   (clk),
        .we    (push),
        .waddr (waddr),
        .wdata (wr_data_i),
        .raddr (raddr),
        .rdata (mem_rd)
    );

    // Output register
    always_ff @(posedge clk) begin
        if (!mrst_n || !prst_n) begin
            dout_q <= '0;
        end else if (pop) begin
            dout_q <= mem_rd;
        end
    end

    // Flags and output drive
    always_comb begin
        rd_flag_o = mode_q ? (state_q != ST_FT_HOLD) : mem_empty;
        wr_flag_o = mem_full;
        half_o    = mem_half;
        rd_data_o = oe_n ? '0 : dout_q;
    end

endmodule

// File: rtl/dmf_checker.sv
module dmf_checker #(
    parameter int W     = 8,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input logic         clk,
    input logic         mrst_n,
    input logic         prst_n,
    input logic         rd_en_n,
    input logic         retx_n,
    input logic         oe_n,
    input logic         mode_q,
    input logic [AW:0]  mem_cnt,
    input logic [W-1:0] dout_q,
    input logic [W-1:0] rd_data_o,
    input logic         rd_flag_o,
    input logic         wr_flag_o,
    input logic         half_o
);

    AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!mrst_n)
        1'b1 |=> $stable(mode_q)); // R1

    AST_STD_NO_READ_HOLD: assert property (@(posedge clk) disable iff (!mrst_n)
        (!mode_q && rd_en_n && prst_n) |=> $stable(dout_q)); // R2

    AST_FT_FETCH: assert property (@(posedge clk) disable iff (!mrst_n)
        (mode_q && rd_flag_o && mem_cnt != '0 && retx_n && prst_n) |=> !rd_flag_o); // R3

    AST_FULL_STICKS: assert property (@(posedge clk) disable iff (!mrst_n)
        (!mode_q && wr_flag_o && rd_en_n && retx_n && prst_n) |=> wr_flag_o); // R4

    AST_HALF_NOT_EMPTY: assert property (@(posedge clk) disable iff (!mrst_n)
        (!mode_q && half_o) |-> !rd_flag_o); // R5

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!mrst_n)
        1'b1 |-> (int'(mem_cnt) <= DEPTH)); // R9

    AST_OE_IDLE: assert property (@(posedge clk) disable iff (!mrst_n)
        oe_n |-> (rd_data_o == '0)); // R10

endmodule

bind dual_mode_fifo dmf_checker #(.W(W), .DEPTH(DEPTH)) u_chk (
    .clk       (clk),
    .mrst_n    (mrst_n),
    .prst_n    (prst_n),
    .rd_en_n   (rd_en_n),
    .retx_n    (retx_n),
    .oe_n      (oe_n),
    .mode_q    (mode_q),
    .mem_cnt   (mem_cnt),
    .dout_q    (dout_q),
    .rd_data_o (rd_data_o),
    .rd_flag_o (rd_flag_o),
    .wr_flag_o (wr_flag_o),
    .half_o    (half_o)
);

// File: tb/tb_dual_mode_fifo.sv
`timescale 1ns/1ps
module tb_dual_mode_fifo;

    localparam int W     = 8;
    localparam int DEPTH = 8;

    logic         clk = 1'b0;
    logic         mrst_n = 1'b0;
    logic         prst_n = 1'b1;
    logic         mode_sel_i = 1'b0;
    logic         wr_en_n = 1'b1;
    logic [W-1:0] wr_data_i = '0;
    logic         rd_en_n = 1'b1;
    logic         oe_n = 1'b0;
    logic         retx_n = 1'b1;
    logic [W-1:0] rd_data_o;
    logic         rd_flag_o;
    logic         wr_flag_o;
    logic         half_o;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;
    int mcount = 0;          // model of standard-mode memory occupancy
    logic [W-1:0] sb_q[$];   // scoreboard: expected read order

    always #2.5 clk = ~clk;

    dual_mode_fifo #(.W(W), .DEPTH(DEPTH)) dut (
        .clk        (clk),
        .mrst_n     (mrst_n),
        .prst_n     (prst_n),
        .mode_sel_i (mode_sel_i),
        .wr_en_n    (wr_en_n),
        .wr_data_i  (wr_data_i),
        .rd_en_n    (rd_en_n),
        .oe_n       (oe_n),
        .retx_n     (retx_n),
        .rd_data_o  (rd_data_o),
        .rd_flag_o  (rd_flag_o),
        .wr_flag_o  (wr_flag_o),
        .half_o     (half_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic mreset(input logic ft);
        mrst_n     = 1'b0;
        mode_sel_i = ft;
        repeat (2) @(negedge clk);
        mrst_n     = 1'b1;
        mode_sel_i = ~ft;    // later changes must not matter
        sb_q.delete();
        mcount = 0;
    endtask

    // Driver: one write, scoreboard push when the model has room
    task automatic push(input logic [W-1:0] d);
        wr_en_n   = 1'b0;
        wr_data_i = d;
        @(negedge clk);
        wr_en_n = 1'b1;
        if (mcount < DEPTH) begin
            sb_q.push_back(d);
            mcount++;
        end
    endtask

    task automatic rd_pulse();
        rd_en_n = 1'b0;
        @(negedge clk);
        rd_en_n = 1'b1;
    endtask

    // Standard-mode read compared against the scoreboard head
    task automatic pop_std(input string tag);
        logic [W-1:0] e;
        rd_pulse();
        if (sb_q.size() > 0) begin
            e = sb_q.pop_front();
            mcount--;
            chk(tag, rd_data_o, e);
        end
    endtask

    task automatic retx_pulse();
        retx_n = 1'b0;
        @(negedge clk);
        retx_n = 1'b1;
    endtask

    initial begin
        #(5.0 * 20000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        // ---------- standard mode ----------
        mreset(1'b0);
        chk("R6 rd_flag after reset", rd_flag_o, 1);
        chk("R6 wr_flag after reset", wr_flag_o, 0);
        chk("R6 half after reset", half_o, 0);
        chk("R6 data after reset", rd_data_o, 0);

        push(8'h11);
        chk("R2 no fall-through in standard mode", rd_data_o, 0);
        chk("R4 not empty after write", rd_flag_o, 0);
        pop_std("R2 read oldest word");
        chk("R4 empty after last read", rd_flag_o, 1);
        rd_pulse();
        chk("R9 read while empty keeps output", rd_data_o, 8'h11);

        for (int i = 0; i < DEPTH; i++) begin
            push(8'h20 + 8'(i));
            if (i == DEPTH/2 - 1) chk("R5 half at DEPTH/2", half_o, 0);
            if (i == DEPTH/2)     chk("R5 half above DEPTH/2", half_o, 1);
        end
        chk("R4 full at DEPTH", wr_flag_o, 1);
        push(8'hEE);  // discarded
        chk("R9 still full after dropped write", wr_flag_o, 1);
        for (int i = 0; i < DEPTH; i++) pop_std("R9 drain order intact");
        chk("R9 empty after drain, dropped word absent", rd_flag_o, 1);

        oe_n = 1'b1; #1;
        chk("R10 idle data while disabled", rd_data_o, 0);
        oe_n = 1'b0; #1;
        chk("R10 held word returns", rd_data_o, 8'h27);

        // retransmit in standard mode
        mreset(1'b0);
        push(8'h31); push(8'h32); push(8'h33);
        for (int i = 0; i < 3; i++) pop_std("R2 sequence before rewind");
        retx_pulse();
        sb_q = '{8'h31, 8'h32, 8'h33};
        mcount = 3;
        chk("R8 data available after rewind", rd_flag_o, 0);
        for (int i = 0; i < 3; i++) pop_std("R8 replay after rewind");

        // partial reset in standard mode
        push(8'h44);
        prst_n = 1'b0; @(negedge clk); prst_n = 1'b1;
        sb_q.delete(); mcount = 0;
        chk("R7 empty after partial reset", rd_flag_o, 1);
        chk("R7 output cleared", rd_data_o, 0);
        push(8'h55);
        @(negedge clk);
        chk("R1 standard mode kept after partial reset", rd_data_o, 0);

        // ---------- fall-through mode ----------
        mreset(1'b1);
        chk("R6 fall-through not ready after reset", rd_flag_o, 1);
        push(8'h61);
        chk("R3 not yet shown one edge after write", rd_flag_o, 1);
        @(negedge clk);
        chk("R3 first word falls through", rd_data_o, 8'h61);
        chk("R4 output ready", rd_flag_o, 0);
        push(8'h62); push(8'h63);
        chk("R3 head held without read", rd_data_o, 8'h61);
        rd_pulse();
        chk("R3 read advances", rd_data_o, 8'h62);
        rd_pulse();
        chk("R3 read advances again", rd_data_o, 8'h63);
        rd_pulse();
        chk("R4 not ready after last consumed", rd_flag_o, 1);
        chk("R9 output kept when drained", rd_data_o, 8'h63);

        retx_pulse();
        chk("R8 output invalid on rewind edge", rd_flag_o, 1);
        @(negedge clk);
        chk("R8 first word refetched", rd_data_o, 8'h61);
        chk("R8 ready after refetch", rd_flag_o, 0);

        mreset(1'b1);
        for (int i = 0; i <= DEPTH; i++) push(8'h70 + 8'(i));
        chk("R4 input not ready with DEPTH stored", wr_flag_o, 1);
        push(8'hEE);  // discarded
        chk("R3 head after fill", rd_data_o, 8'h70);
        for (int i = 1; i <= DEPTH; i++) begin
            rd_pulse();
            chk("R9 fall-through order intact", rd_data_o, 8'h70 + i);
        end
        rd_pulse();
        chk("R9 dropped word never appears", rd_flag_o, 1);

        prst_n = 1'b0; @(negedge clk); prst_n = 1'b1;
        chk("R7 fall-through output cleared", rd_data_o, 0);
        push(8'h81);
        @(negedge clk);
        chk("R1 fall-through kept after partial reset", rd_data_o, 8'h81);

        mreset(1'b0);
        push(8'h91);
        @(negedge clk);
        chk("R1 mode re-captured as standard", rd_data_o, 0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule